// File: doc/BRIEF.md
# Digital Regulator Switch-Array Controller

This block is the clocked control loop of a digital low-dropout regulator. Each sampling tick it reads a one-bit comparator verdict (output voltage under or over the reference) and moves a count of enabled parallel power switches up or down. The count is presented to the switch array as a thermometer-coded enable bus: each gate is either fully on or fully off.

The loop normally samples once every eight clocks and moves one switch per sample. A long run of same-polarity verdicts marks a large droop or overshoot. The controller then samples on every clock and moves four switches at a time. Two reversals in a row show that the loop has settled, and it drops back to the slow rate.

Software selects between regulation, a bypass in which every switch is held on, and an idle state in which every switch is off. The comparator, the reference, the power devices and the clock source are outside the block.

Top module: `dldo_ctrl`

## Requirements
- R1: While rst_ni is low, count_o is 0, fast_o is 0 and every bit of sw_en_o is 0.
- R2: In slow mode (fast_o=0) with regulation active (en_i=1, bypass_i=0), cmp_low_i is sampled on every 8th clock after activation or after the previous slow sample, and count_o moves by exactly 1 at that edge.
- R3: cmp_low_i=1 means the output is below the reference and the count increases; cmp_low_i=0 means it is above and the count decreases.
- R4: count_o saturates at 64 on the way up and at 0 on the way down.
- R5: With en_i=1 and bypass_i=0, sw_en_o[i] is 1 exactly when i < count_o (thermometer code, bit 0 first).
- R6: The 4th consecutive sample of equal polarity in slow mode still moves 1 switch and sets fast_o. From the next clock, every clock is a sample and moves 4 switches.
- R7: In fast mode, a sample that differs from the one before it is a reversal, and a sample equal to the one before it clears the reversal tally. On the second consecutive reversal, that sample still moves 4 switches and fast_o clears. The next slow sample is due 8 clocks later.
- R8: With bypass_i=1, sw_en_o is all ones whatever en_i is, count_o holds, fast_o is 0 and cmp_low_i has no effect.
- R9: With en_i=0 and bypass_i=0, sw_en_o is all zeros in the same cycle, count_o is 0 from the next edge on, and cmp_low_i has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Software regulation enable |
| bypass_i | input | 1 | Force every switch on and stop regulating |
| cmp_low_i | input | 1 | Comparator verdict: 1 means output below reference |
| sw_en_o | output | 64 | Thermometer-coded switch gate enables |
| count_o | output | 7 | Number of enabled switches |
| fast_o | output | 1 | Fast sampling mode active |

## Verification
Count and mode are registered, so a slow-mode result shows up on the 8th rising edge after activation or after the previous slow sample. In fast mode it shows up on the very next edge. The enable bus follows the count, en_i and bypass_i without delay. The bench drives the comparator at a falling edge and waits exactly 8 or 1 falling edges, chosen from the mode it expects. It then compares count, mode and the full enable bus against values it works out itself. For the slow period it checks one clock early as well as on time, and it checks bypass and disable both in the same cycle and after further edges.

// File: rtl/dldo_pkg.sv
package dldo_pkg;
  typedef enum logic {
    MODE_SLOW = 1'b0,
    MODE_FAST = 1'b1
  } mode_e;
endpackage

// File: rtl/dldo_tick_gen.sv
module dldo_tick_gen #(
  parameter int SLOW_DIV = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic fast_i,
  output logic tick_o
);
  localparam int DIV_W = (SLOW_DIV > 2) ? $clog2(SLOW_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SLOW_DIV - 1);

  logic [DIV_W-1:0] div_q;
  logic             wrap;

  assign wrap   = (div_q == DIV_LAST);
  assign tick_o = active_i && (fast_i || wrap);

  // divider restarts whenever it is not pacing slow samples
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          div_q <= '0;
    else if (!active_i || fast_i || wrap) div_q <= '0;
    else                                  div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/dldo_excursion_det.sv
module dldo_excursion_det
  import dldo_pkg::*;
#(
  parameter int RUN_LEN = 4,
  parameter int REV_LEN = 2
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  active_i,
  input  logic  tick_i,
  input  logic  cmp_low_i,
  output mode_e mode_o
);
  localparam int RUN_W = $clog2(RUN_LEN + 1);
  localparam int REV_W = $clog2(REV_LEN + 1);

  mode_e            mode_q, mode_d;
  logic             last_q;
  logic [RUN_W-1:0] run_q, run_d;
  logic [REV_W-1:0] rev_q, rev_d;

  always_comb begin
    mode_d = mode_q;
    run_d  = run_q;
    rev_d  = rev_q;
    if (mode_q == MODE_SLOW) begin
      // run_q == 0 means no earlier sample to compare with
      if (run_q != '0 && cmp_low_i == last_q) run_d = run_q + 1'b1;
      else                                    run_d = RUN_W'(1);
      if (run_d == RUN_W'(RUN_LEN)) begin
        mode_d = MODE_FAST;
        run_d  = '0;
        rev_d  = '0;
      end
    end else begin
      if (cmp_low_i != last_q) begin
        rev_d = rev_q + 1'b1;
        if (rev_d == REV_W'(REV_LEN)) begin
          mode_d = MODE_SLOW;
          rev_d  = '0;
          run_d  = RUN_W'(1);
        end
      end else begin
        rev_d = '0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_SLOW;
      last_q <= 1'b0;
      run_q  <= '0;
      rev_q  <= '0;
    end else if (!active_i) begin
      mode_q <= MODE_SLOW;
      last_q <= 1'b0;
      run_q  <= '0;
      rev_q  <= '0;
    end else if (tick_i) begin
      mode_q <= mode_d;
      last_q <= cmp_low_i;
      run_q  <= run_d;
      rev_q  <= rev_d;
    end
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/dldo_step_cnt.sv
module dldo_step_cnt #(
  parameter int N_SW      = 64,
  parameter int CNT_W     = 7,
  parameter int SLOW_STEP = 1,
  parameter int FAST_STEP = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             bypass_i,
  input  logic             tick_i,
  input  logic             fast_i,
  input  logic             cmp_low_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q, cnt_step;
  int               step, up, dn;

  always_comb begin
    step = fast_i ? FAST_STEP : SLOW_STEP;
    up   = int'(cnt_q) + step;
    dn   = int'(cnt_q) - step;
    if (cmp_low_i) cnt_step = (up > N_SW) ? CNT_W'(N_SW) : CNT_W'(up);
    else           cnt_step = (dn < 0)    ? '0           : CNT_W'(dn);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (bypass_i)          cnt_q <= cnt_q;
    else if (!en_i)             cnt_q <= '0;
    else if (tick_i)            cnt_q <= cnt_step;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/dldo_therm_enc.sv
module dldo_therm_enc #(
  parameter int N_SW  = 64,
  parameter int CNT_W = 7
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             on_i,
  input  logic             force_i,
  output logic [N_SW-1:0]  sw_o
);
  for (genvar i = 0; i < N_SW; i++) begin : g_bit
    assign sw_o[i] = force_i | (on_i & (cnt_i > CNT_W'(i)));
  end
endmodule

// File: rtl/dldo_ctrl.sv
module dldo_ctrl
  import dldo_pkg::*;
#(
  parameter int N_SW      = 64,
  parameter int SLOW_DIV  = 8,
  parameter int RUN_LEN   = 4,
  parameter int REV_LEN   = 2,
  parameter int SLOW_STEP = 1,
  parameter int FAST_STEP = 4,
  localparam int CNT_W    = $clog2(N_SW + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             bypass_i,
  input  logic             cmp_low_i,
  output logic [N_SW-1:0]  sw_en_o,
  output logic [CNT_W-1:0] count_o,
  output logic             fast_o
);
  logic  active, tick;
  mode_e mode;

  assign active = en_i & ~bypass_i;
  assign fast_o = (mode == MODE_FAST);

  dldo_tick_gen #(.SLOW_DIV(SLOW_DIV)) i_tick (
    .clk_i, .rst_ni, .active_i(active), .fast_i(fast_o), .tick_o(tick)
  );

  dldo_excursion_det #(.RUN_LEN(RUN_LEN), .REV_LEN(REV_LEN)) i_det (
    .clk_i, .rst_ni, .active_i(active), .tick_i(tick),
    .cmp_low_i, .mode_o(mode)
  );

  dldo_step_cnt #(
    .N_SW(N_SW), .CNT_W(CNT_W), .SLOW_STEP(SLOW_STEP), .FAST_STEP(FAST_STEP)
  ) i_cnt (
    .clk_i, .rst_ni, .en_i, .bypass_i, .tick_i(tick), .fast_i(fast_o),
    .cmp_low_i, .cnt_o(count_o)
  );

  dldo_therm_enc #(.N_SW(N_SW), .CNT_W(CNT_W)) i_enc (
    .cnt_i(count_o), .on_i(en_i), .force_i(bypass_i), .sw_o(sw_en_o)
  );
endmodule

// File: rtl/dldo_ctrl_chk.sv
module dldo_ctrl_chk #(
  parameter int N_SW      = 64,
  parameter int SLOW_STEP = 1,
  parameter int FAST_STEP = 4,
  parameter int CNT_W     = 7
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             bypass_i,
  input logic [N_SW-1:0]  sw_en_o,
  input logic [CNT_W-1:0] count_o,
  input logic             fast_o
);
  a_r4_cnt_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(count_o) <= N_SW);

  a_r5_therm_shape: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !bypass_i) |-> (((sw_en_o + 1'b1) & sw_en_o) == '0));

  a_r5_therm_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !bypass_i) |-> ($countones(sw_en_o) == int'(count_o)));

  a_r2_slow_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !bypass_i && !fast_o) |=>
      (int'(count_o) <= int'($past(count_o)) + SLOW_STEP &&
       int'($past(count_o)) <= int'(count_o) + SLOW_STEP));

  a_r6_fast_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !bypass_i && fast_o) |=>
      (int'(count_o) <= int'($past(count_o)) + FAST_STEP &&
       int'($past(count_o)) <= int'(count_o) + FAST_STEP));

  a_r8_bypass_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bypass_i |-> (&sw_en_o));

  a_r8_bypass_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bypass_i |=> (count_o == $past(count_o)));

  a_r8_bypass_slow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bypass_i |=> !fast_o);

  a_r9_idle_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !bypass_i) |-> (sw_en_o == '0));

  a_r9_idle_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !bypass_i) |=> (count_o == '0 && !fast_o));
endmodule

bind dldo_ctrl dldo_ctrl_chk #(
  .N_SW(N_SW), .SLOW_STEP(SLOW_STEP), .FAST_STEP(FAST_STEP), .CNT_W(CNT_W)
) i_chk (
  .clk_i, .rst_ni, .en_i, .bypass_i, .sw_en_o, .count_o, .fast_o
);

// File: tb/test_dldo_ctrl.sv
module test_dldo_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N_SW       = 64;
  localparam int CNT_W      = 7;
  localparam int WATCHDOG   = 5000;
  localparam int N_VEC      = 12;

  // {cmp_low, expected count, expected fast}
  typedef struct packed {
    logic       cmp;
    logic [6:0] cnt;
    logic       fast;
  } vec_t;

  localparam vec_t VECS [N_VEC] = '{
    '{1'b1, 7'd1,  1'b0}, '{1'b1, 7'd2,  1'b0}, '{1'b1, 7'd3,  1'b0},
    '{1'b1, 7'd4,  1'b1}, '{1'b1, 7'd8,  1'b1}, '{1'b1, 7'd12, 1'b1},
    '{1'b0, 7'd8,  1'b1}, '{1'b1, 7'd12, 1'b0}, '{1'b1, 7'd13, 1'b0},
    '{1'b0, 7'd12, 1'b0}, '{1'b0, 7'd11, 1'b0}, '{1'b1, 7'd12, 1'b0}
  };

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             en_i = 1'b0;
  logic             bypass_i = 1'b0;
  logic             cmp_low_i = 1'b0;
  logic [N_SW-1:0]  sw_en_o;
  logic [CNT_W-1:0] count_o;
  logic             fast_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dldo_ctrl i_dldo_ctrl (
    .clk_i(clk), .rst_ni, .en_i, .bypass_i, .cmp_low_i,
    .sw_en_o, .count_o, .fast_o
  );

  function automatic logic [N_SW-1:0] therm(int n);
    if (n >= N_SW) return '1;
    return (N_SW'(1) << n) - 1'b1;
  endfunction

  task automatic chk_int(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_sw(string req, logic [N_SW-1:0] exp);
    checks++;
    if (sw_en_o !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, sw_en_o, exp);
    end
  endtask

  task automatic state(string req, int cnt, int fst, logic [N_SW-1:0] sw);
    chk_int(req, int'(count_o), cnt);
    chk_int(req, int'(fast_o), fst);
    chk_sw(req, sw);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic prev_fast;
    en_i = 1'b1;
    repeat (2) @(negedge clk);
    state("R1 reset", 0, 0, '0);
    rst_ni = 1'b1;

    // R2 R3 R5 R6 R7: table walk, wait chosen from expected mode
    prev_fast = 1'b0;
    for (int k = 0; k < N_VEC; k++) begin
      cmp_low_i = VECS[k].cmp;
      repeat (prev_fast ? 1 : 8) @(negedge clk);
      state($sformatf("R2/R3/R5/R6/R7 vec %0d", k),
            int'(VECS[k].cnt), int'(VECS[k].fast), therm(int'(VECS[k].cnt)));
      prev_fast = VECS[k].fast;
    end

    // R4 top saturation: 3 slow samples then fast climb
    cmp_low_i = 1'b1;
    repeat (24 + 20) @(negedge clk);
    state("R4 top", 64, 1, '1);
    // R4 bottom saturation in fast mode
    cmp_low_i = 1'b0;
    repeat (20) @(negedge clk);
    state("R4 bottom", 0, 1, '0);
    // R7 two reversals end fast mode
    cmp_low_i = 1'b1;
    @(negedge clk);
    state("R7 first reversal", 4, 1, therm(4));
    cmp_low_i = 1'b0;
    @(negedge clk);
    state("R7 second reversal", 0, 0, '0);

    // R8 bypass
    bypass_i  = 1'b1;
    cmp_low_i = 1'b1;
    #1;
    chk_sw("R8 bypass immediate", '1);
    repeat (20) @(negedge clk);
    state("R8 bypass hold", 0, 0, '1);
    en_i = 1'b0;
    #1;
    chk_sw("R8 bypass over disable", '1);
    @(negedge clk);
    en_i     = 1'b1;
    bypass_i = 1'b0;
    repeat (7) @(negedge clk);
    state("R2 slow not yet due", 0, 0, '0);
    @(negedge clk);
    state("R2 slow sample due", 1, 0, therm(1));

    // R9 disable
    en_i = 1'b0;
    #1;
    chk_sw("R9 off same cycle", '0);
    @(negedge clk);
    chk_int("R9 count cleared", int'(count_o), 0);
    repeat (20) @(negedge clk);
    state("R9 cmp ignored", 0, 0, '0);

    // R1 reset during regulation
    en_i = 1'b1;
    repeat (16) @(negedge clk);
    chk_int("R3 resumed rise", int'(count_o), 2);
    rst_ni = 1'b0;
    #1;
    state("R1 async reset", 0, 0, '0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule